// File: doc/BRIEF.md
# I2C EEPROM Read-Side Target

This block is an I2C target that answers read transfers for a small serial EEPROM model. It watches SCL and SDA through synchronizers clocked by a fast system clock, recognises START, repeated START and STOP, and accepts a device select byte. The select byte carries the code in bits 7:1 and the direction in bit 0, where 1 means read. It drives SDA only as an open-drain pull-down through an output-enable. The array behind it holds 2^ADDR_W bytes, 128 by default, and is preloaded through a synchronous side write port.

A persistent byte-address counter selects the next byte to send. A write-direction transfer that carries one address byte and then, without a STOP, a repeated START, loads that counter. This gives random reads. A read select on its own starts at the current counter value, which gives current-address reads. After each byte the controller either acknowledges, and the target sends the next byte at the following address, or withholds the acknowledge, which ends the data. Bytes go out most significant bit first. An acknowledge is SDA low during the ninth clock.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: After reset, SDA is released (output-enable low) and the address counter is 0, so the first current-address read returns the byte at address 0.
- R2: A select byte whose bits 7:1 equal DEV_ID is acknowledged with SDA low on the ninth clock. Any other select is not acknowledged, and SDA stays released until the next START.
- R3: A read select (bit 0 = 1) after START is acknowledged and followed by the byte at the counter, with no address phase.
- R4: A write select (bit 0 = 0) followed by one byte loads the counter with the low ADDR_W bits of that byte. Bit 7 is ignored. Both bytes are acknowledged.
- R5: After the address load, a repeated START with a read select returns the byte at the loaded address. No STOP is needed in between.
- R6: The counter advances by one after every byte sent. In sequential reads it wraps from the last address to 0.
- R7: When the controller does not acknowledge a data byte, the target releases SDA and sends nothing more until the next START.
- R8: A STOP returns the target to idle, and the counter value survives across transfers.
- R9: If the repeated-START read select that follows an address load carries a different code, it is not acknowledged, and the counter keeps the loaded address.
- R10: A START in the middle of a byte abandons it and restarts select reception.
- R11: The target changes SDA only while SCL is low, and it releases SDA during the acknowledge bit that follows each data byte.
- R12: A write on the side port stores a byte that a later bus read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| bk_we_i | input | 1 | Side-port write strobe |
| bk_addr_i | input | ADDR_W | Side-port write address |
| bk_data_i | input | 8 | Side-port write data |

## Verification
The bench keeps the default ADDR_W of 7, so the wrap from 127 to 0 is reached within a four-byte sequential read. It overrides DEV_ID to 7'h53, which shows that select matching follows the parameter and not a fixed code. SYNC_STAGES stays at 2, and with a quarter-bit of ten system clocks the synchronizer latency remains well inside each SCL phase.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ACK_DEV,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } bus_state_t;

  // select byte: code in [7:1], direction in [0]
  function automatic logic dev_hit(input logic [7:0] sel, input logic [6:0] id);
    return sel[7:1] == id;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
  import i2c_eep_pkg::*;
#(
  parameter int         ADDR_W = 7,
  parameter logic [6:0] DEV_ID = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] addr_cnt,
  output bus_state_t        state,
  output logic              tx_load,
  output logic              addr_load,
  output logic [7:0]        rx_byte
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [3:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rw_q;
  logic       mst_ack;
  logic       byte_in;

  assign rx_byte   = rx_sh;
  assign byte_in   = (bit_cnt == BYTE_BITS);
  assign tx_load   = scl_fall & (((state == ST_ACK_DEV) & rw_q) |
                                 ((state == ST_RACK) & mst_ack));
  assign addr_load = scl_fall & (state == ST_ADDR) & byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_q     <= 1'b0;
      mst_ack  <= 1'b0;
      sda_oe   <= 1'b0;
      addr_cnt <= '0;
    end else if (start_det) begin
      state   <= ST_DEVSEL;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (tx_load) begin
      tx_sh    <= rd_data;
      sda_oe   <= ~rd_data[7];
      addr_cnt <= addr_step(addr_cnt);
      bit_cnt  <= 4'd1;
      state    <= ST_TX;
    end else begin
      unique case (state)
        ST_DEVSEL, ST_ADDR: begin
          if (scl_rise && !byte_in) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (scl_fall && byte_in) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              addr_cnt <= rx_sh[ADDR_W-1:0];
              sda_oe   <= 1'b1;
              state    <= ST_ACK_ADDR;
            end else if (dev_hit(rx_sh, DEV_ID)) begin
              rw_q   <= rx_sh[0];
              sda_oe <= 1'b1;
              state  <= ST_ACK_DEV;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ACK_DEV: begin
          // read direction handled by tx_load
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_ADDR;
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WAIT;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (byte_in) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mst_ack <= ~sda_s;
          if (scl_fall) state <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
  import i2c_eep_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter logic [6:0] DEV_ID      = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              bk_we_i,
  input  logic [ADDR_W-1:0] bk_addr_i,
  input  logic [7:0]        bk_data_i
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] addr_cnt;
  bus_state_t        state;
  logic              tx_load;
  logic              addr_load;
  logic [7:0]        rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_evt),
    .stop_det  (stop_evt)
  );

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(8)) mem_i (
    .clk   (clk),
    .we    (bk_we_i),
    .waddr (bk_addr_i),
    .wdata (bk_data_i),
    .raddr (addr_cnt),
    .rdata (rd_data)
  );

  i2c_rd_fsm #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_evt),
    .stop_det  (stop_evt),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .addr_cnt  (addr_cnt),
    .state     (state),
    .tx_load   (tx_load),
    .addr_load (addr_load),
    .rx_byte   (rx_byte)
  );

endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
module i2c_eeprom_rd_chk
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              sda_oe_o,
  input bus_state_t        state,
  input logic              tx_load,
  input logic              addr_load,
  input logic [7:0]        rx_byte,
  input logic [ADDR_W-1:0] addr_cnt
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!scl_s || $past(start_evt || stop_evt))); // R11

  AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe_o); // R7

  AST_UNSEL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe_o); // R2

  AST_DEVACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_DEV) |-> sda_oe_o); // R2

  AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEVSEL)); // R10

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (state == ST_IDLE)); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (addr_cnt == ADDR_W'($past(addr_cnt) + 1'b1))); // R6

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (addr_cnt == $past(rx_byte[ADDR_W-1:0]))); // R4

endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_oe_o  (sda_oe_o),
  .state     (state),
  .tx_load   (tx_load),
  .addr_load (addr_load),
  .rx_byte   (rx_byte),
  .addr_cnt  (addr_cnt)
);

// File: tb/i2c_eeprom_rd_tb_top.sv
module i2c_eeprom_rd_tb_top;

  localparam int         AW = 7;
  localparam logic [6:0] ID = 7'h53;
  localparam int         Q  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1;
  logic          tb_sda = 1'b1;
  logic          sda_oe;
  logic          sda_line;
  logic          bk_we = 1'b0;
  logic [AW-1:0] bk_addr = '0;
  logic [7:0]    bk_data = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [AW-1:0] mdl;

  always #5 clk = ~clk;

  assign sda_line = tb_sda & ~sda_oe;

  i2c_eeprom_rd #(.ADDR_W(AW), .DEV_ID(ID), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .bk_we_i   (bk_we),
    .bk_addr_i (bk_addr),
    .bk_data_i (bk_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 60) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    tb_sda = 1'b1; scl = 1'b1; wq(Q);
    tb_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic b_rstart();
    tb_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    tb_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    tb_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    tb_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    tb_sda = b; wq(Q);
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    tb_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    chk("R1 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_current(input int nbytes, input string req);
    logic a;
    logic [7:0] d;
    b_start();
    put_byte({ID, 1'b1}, a);
    chk({req, " R3 read select ack"}, a, 1);
    for (int k = 0; k < nbytes; k++) begin
      get_byte(d, k != nbytes - 1);
      chk({req, " R3 current data"}, d, pat(int'(mdl)));
      mdl = mdl + 1'b1;
    end
    b_stop();
    chk("R8 released after stop", sda_oe, 0);
  endtask

  task automatic t_random(input logic [7:0] adr, input int nbytes);
    logic a;
    logic [7:0] d;
    b_start();
    put_byte({ID, 1'b0}, a);
    chk("R4 write select ack", a, 1);
    put_byte(adr, a);
    chk("R4 address byte ack", a, 1);
    mdl = adr[AW-1:0];
    b_rstart();
    put_byte({ID, 1'b1}, a);
    chk("R5 read select after rstart ack", a, 1);
    for (int k = 0; k < nbytes; k++) begin
      get_byte(d, k != nbytes - 1);
      chk("R5 R6 random/sequential data", d, pat(int'(mdl)));
      mdl = mdl + 1'b1;
    end
    b_stop();
  endtask

  task automatic t_wrong_select();
    logic a;
    logic [7:0] d;
    b_start();
    put_byte({7'h2A, 1'b1}, a);
    chk("R2 foreign select not acked", a, 0);
    get_byte(d, 1'b1);
    chk("R2 line released while unselected", d, 8'hFF);
    b_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    logic [7:0] d;
    b_start();
    put_byte({ID, 1'b0}, a);
    put_byte(8'h30, a);
    chk("R9 address ack", a, 1);
    mdl = 7'h30;
    b_rstart();
    put_byte({ID ^ 7'h01, 1'b1}, a);
    chk("R9 differing read select not acked", a, 0);
    get_byte(d, 1'b0);
    chk("R9 no data after rejected select", d, 8'hFF);
    b_stop();
  endtask

  task automatic t_nack_release();
    logic [7:0] d;
    logic a;
    b_start();
    put_byte({ID, 1'b0}, a);
    put_byte(8'h10, a);
    b_rstart();
    put_byte({ID, 1'b1}, a);
    get_byte(d, 1'b0);
    chk("R7 data before nack", d, pat(16));
    get_byte(d, 1'b0);
    chk("R7 released after nack", d, 8'hFF);
    b_stop();
    mdl = 7'h11;
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    b_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    b_rstart();
    put_byte({ID, 1'b1}, a);
    chk("R10 select after mid-byte start acked", a, 1);
    get_byte(d, 1'b0);
    chk("R10 data after restart", d, pat(int'(mdl)));
    mdl = mdl + 1'b1;
    b_stop();
  endtask

  task automatic t_backdoor();
    logic a;
    logic [7:0] d;
    @(negedge clk);
    bk_we = 1'b1; bk_addr = mdl; bk_data = 8'hA5;
    @(negedge clk);
    bk_we = 1'b0;
    b_start();
    put_byte({ID, 1'b1}, a);
    get_byte(d, 1'b0);
    chk("R12 side-port byte read back", d, 8'hA5);
    b_stop();
    mdl = mdl + 1'b1;
  endtask

  initial begin
    wq(3);
    for (int i = 0; i < (1 << AW); i++) begin
      bk_we = 1'b1; bk_addr = AW'(i); bk_data = pat(i);
      @(negedge clk);
    end
    bk_we = 1'b0;
    rst_n = 1'b1;
    wq(4);
    mdl = '0;
    t_reset();
    t_current(1, "R1 first read from 0");
    t_random(8'h55, 1);
    t_current(1, "R8 counter persists");
    t_random(8'hFE, 4);
    t_current(3, "R6 sequential current");
    t_wrong_select();
    t_current(1, "R2 counter untouched");
    t_mismatch();
    t_current(1, "R9 counter keeps loaded");
    t_nack_release();
    t_current(1, "R7 counter after nack");
    t_abort();
    t_backdoor();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule